// File: doc/BRIEF.md
# T1/E1 Loopback Path Controller

This block sits between the line interface and the framer of a T1/E1 transceiver. It decides where each bit stream goes. A small control register is reached through a byte-addressed write port. It holds three loopback enables and two extra control bits. From the enables, the block picks one effective loopback mode and steers four groups of streams: the line receive rails, the transmit formatter output, the system transmit serial data, and the receive payload stream. It also raises clock-select flags that tell the clocking logic which clock must time each looped path.

In framer loopback, transmit data is fed back into the receive framer. The line then carries either the formatter output (E1) or an unframed all-ones pattern (T1). In payload loopback, the receive payload is handed to the transmit side in place of system data. Overhead positions, flagged by a qualifier input, come from a local regeneration stream. In remote loopback, the line receive rails are echoed onto the line transmit rails, and the receive framer keeps seeing the line. Framing, CRC and line coding are outside this block. They appear only as external streams plus the overhead-position flag.

Top module: `lbk_path_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0, `lb_status` is 0, both clock-select flags are 0 and routing is normal.
- R2: A write with `cfg_wr_en` high and `cfg_addr` equal to 0x4A loads `cfg_wdata` into the register, which is visible on `cfg_q` after the next rising clock edge. A write to any other address, or with `cfg_wr_en` low, leaves the register unchanged. Bit 0 enables framer loopback, bit 1 payload loopback, bit 2 remote loopback, and bits 3 and 4 are stored control bits.
- R3: The effective mode gives remote precedence over payload and payload over framer. `lb_status` is one-hot or zero: bit 2 = remote, bit 1 = payload, bit 0 = framer. The two clock-select flags are never high together.
- R4: With no loopback effective, `ln_tx` follows `fmt_tx`, `fr_rx` follows `ln_rx`, and `tx_src_d` follows `sys_tx_d`.
- R5: In framer loopback, `fr_rx` follows `fmt_tx`, the line receive rails have no effect, and `rx_on_tclk` is 1.
- R6: In framer loopback with `e1_mode` = 0, the line transmit rails carry alternating marks: the two rails differ in every cycle, and the positive rail inverts every clock. With `e1_mode` = 1, the line transmit rails follow `fmt_tx`.
- R7: In payload loopback, `tx_src_d` equals `rx_pay_d` when `ovh_pos` is 0 and `ovh_regen_d` when `ovh_pos` is 1, so `sys_tx_d` is ignored. `tx_on_rclk` is 1, `fr_rx` still follows `ln_rx`, and `ln_tx` follows `fmt_tx`.
- R8: In remote loopback, `ln_tx` follows `ln_rx`, `fr_rx` follows `ln_rx`, the formatter output has no effect, `tx_src_d` follows `sys_tx_d`, and both clock-select flags are 0.
- R9: Control bits 3 and 4 are stored and shown on `cfg_q` but change neither the routing nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock for the register and the all-ones generator |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 5 | Register write data |
| e1_mode | input | 1 | 1 = E1 framing, 0 = T1 framing |
| ln_rx_p | input | 1 | Line receive positive rail |
| ln_rx_n | input | 1 | Line receive negative rail |
| fmt_tx_p | input | 1 | Transmit formatter positive rail |
| fmt_tx_n | input | 1 | Transmit formatter negative rail |
| sys_tx_d | input | 1 | System transmit serial data |
| rx_pay_d | input | 1 | Corrected receive payload stream |
| ovh_regen_d | input | 1 | Locally regenerated overhead bit |
| ovh_pos | input | 1 | High on overhead bit positions |
| ln_tx_p | output | 1 | Line transmit positive rail |
| ln_tx_n | output | 1 | Line transmit negative rail |
| fr_rx_p | output | 1 | Receive framer positive rail |
| fr_rx_n | output | 1 | Receive framer negative rail |
| tx_src_d | output | 1 | Data into the transmit side |
| rx_on_tclk | output | 1 | Receive side must run on the transmit clock |
| tx_on_rclk | output | 1 | Line transmit and its clock output must run on the receive clock |
| lb_status | output | 3 | Effective mode, one-hot |
| cfg_q | output | 5 | Current register contents |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 5-bit control field and the register at 0x4A. With the full 8-bit address, the neighbouring addresses 0x4B and 0x49 are reachable for write-miss cases. The 5-bit field lets every enable combination, including all three enables set, be loaded in one write. The T1 all-ones pattern is observed over consecutive cycles, because its phase comes from state and not from the inputs.

// File: rtl/lbk_pkg.sv
// Package lbk_pkg: shared field positions and mode type for the loopback controller.
// Assumes a single control register whose low bits carry the loopback enables.
package lbk_pkg;
    localparam int unsigned CFG_W    = 5;
    localparam int unsigned BIT_FRM  = 0;
    localparam int unsigned BIT_PAY  = 1;
    localparam int unsigned BIT_REM  = 2;
    localparam int unsigned LB_REQ_W = 3;

    typedef enum logic [1:0] {
        LB_NONE    = 2'd0,
        LB_FRAMER  = 2'd1,
        LB_PAYLOAD = 2'd2,
        LB_REMOTE  = 2'd3
    } lb_mode_e;
endpackage

// File: rtl/lbk_cfg_reg.sv
// Module lbk_cfg_reg: holds the loopback control field and loads it on an
// address hit. Assumes the write port is synchronous to clk; there is no read path.
module lbk_cfg_reg #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CFG_W    = 5,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h4A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [CFG_W-1:0]  cfg_q
);
    logic hit;

    // Decode a write aimed at this register.
    always_comb hit = wr_en && (wr_addr == CFG_ADDR);

    // One flop per control bit, each cleared by reset and loaded on a hit.
    for (genvar i = 0; i < CFG_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)   cfg_q[i] <= 1'b0;
            else if (hit) cfg_q[i] <= wr_data[i];
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == CFG_ADDR)) |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/lbk_mode_arb.sv
// Module lbk_mode_arb: turns the raw loopback enables into one effective mode
// with fixed precedence remote > payload > framer. Purely combinational;
// the clock and reset only qualify the assertions.
module lbk_mode_arb
    import lbk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LB_REQ_W-1:0] lb_req,
    output lb_mode_e            mode,
    output logic [LB_REQ_W-1:0] status
);
    // Pick the highest-precedence enabled loopback.
    always_comb begin
        if (lb_req[BIT_REM])      mode = LB_REMOTE;
        else if (lb_req[BIT_PAY]) mode = LB_PAYLOAD;
        else if (lb_req[BIT_FRM]) mode = LB_FRAMER;
        else                      mode = LB_NONE;
    end

    // Report the effective mode as a one-hot vector.
    always_comb begin
        status = '0;
        case (mode)
            LB_FRAMER:  status[BIT_FRM] = 1'b1;
            LB_PAYLOAD: status[BIT_PAY] = 1'b1;
            LB_REMOTE:  status[BIT_REM] = 1'b1;
            default:    status = '0;
        endcase
    end

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status)); // R3
    AST_REMOTE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lb_req[BIT_REM] |-> status[BIT_REM]); // R3
endmodule

// File: rtl/lbk_route.sv
// Module lbk_route: steers the line, framer and transmit-source streams for the
// selected mode and produces the T1 unframed all-ones line pattern as alternating
// marks. Assumes clk is the transmit bit clock; the overhead flag is bit-aligned.
module lbk_route
    import lbk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lb_mode_e mode,
    input  logic     e1_mode,
    input  logic     ln_rx_p,
    input  logic     ln_rx_n,
    input  logic     fmt_tx_p,
    input  logic     fmt_tx_n,
    input  logic     sys_tx_d,
    input  logic     rx_pay_d,
    input  logic     ovh_regen_d,
    input  logic     ovh_pos,
    output logic     ln_tx_p,
    output logic     ln_tx_n,
    output logic     fr_rx_p,
    output logic     fr_rx_n,
    output logic     tx_src_d,
    output logic     rx_on_tclk,
    output logic     tx_on_rclk
);
    logic mark_ph;
    logic t1_ones;

    // Free-running mark phase: alternates the rail carrying each one.
    always_ff @(posedge clk) begin
        if (!rst_n) mark_ph <= 1'b0;
        else        mark_ph <= ~mark_ph;
    end

    // T1 framer loopback replaces the line output with all ones.
    always_comb t1_ones = (mode == LB_FRAMER) && !e1_mode;

    // Line transmit rails: echo, all ones, or formatter output.
    always_comb begin
        if (mode == LB_REMOTE) begin
            ln_tx_p = ln_rx_p;
            ln_tx_n = ln_rx_n;
        end else if (t1_ones) begin
            ln_tx_p = mark_ph;
            ln_tx_n = ~mark_ph;
        end else begin
            ln_tx_p = fmt_tx_p;
            ln_tx_n = fmt_tx_n;
        end
    end

    // Receive framer input: the formatter in framer loopback, else the line.
    always_comb begin
        if (mode == LB_FRAMER) begin
            fr_rx_p = fmt_tx_p;
            fr_rx_n = fmt_tx_n;
        end else begin
            fr_rx_p = ln_rx_p;
            fr_rx_n = ln_rx_n;
        end
    end

    // Transmit source: looped payload with regenerated overhead, else system data.
    always_comb begin
        if (mode == LB_PAYLOAD) tx_src_d = ovh_pos ? ovh_regen_d : rx_pay_d;
        else                    tx_src_d = sys_tx_d;
    end

    // Clock-select flags for the clocking logic outside this block.
    always_comb begin
        rx_on_tclk = (mode == LB_FRAMER);
        tx_on_rclk = (mode == LB_PAYLOAD);
    end

    AST_ONES_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == LB_FRAMER) && !e1_mode) |-> (ln_tx_p != ln_tx_n)); // R6
    AST_ONES_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == LB_FRAMER) && !e1_mode && $past((mode == LB_FRAMER) && !e1_mode))
        |-> (ln_tx_p != $past(ln_tx_p))); // R6
    AST_PAY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == LB_PAYLOAD) && !ovh_pos) |-> (tx_src_d == rx_pay_d)); // R7
endmodule

// File: rtl/lbk_path_ctrl.sv
// Module lbk_path_ctrl: top of the loopback path controller. Holds the control
// register, resolves the effective mode, and routes the streams. Assumes all
// stream inputs are sampled elsewhere on the clock that the flags select.
module lbk_path_ctrl
    import lbk_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h4A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                e1_mode,
    input  logic                ln_rx_p,
    input  logic                ln_rx_n,
    input  logic                fmt_tx_p,
    input  logic                fmt_tx_n,
    input  logic                sys_tx_d,
    input  logic                rx_pay_d,
    input  logic                ovh_regen_d,
    input  logic                ovh_pos,
    output logic                ln_tx_p,
    output logic                ln_tx_n,
    output logic                fr_rx_p,
    output logic                fr_rx_n,
    output logic                tx_src_d,
    output logic                rx_on_tclk,
    output logic                tx_on_rclk,
    output logic [LB_REQ_W-1:0] lb_status,
    output logic [CFG_W-1:0]    cfg_q
);
    lb_mode_e mode;

    lbk_cfg_reg #(
        .ADDR_W   (ADDR_W),
        .CFG_W    (CFG_W),
        .CFG_ADDR (CFG_ADDR)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q)
    );

    lbk_mode_arb i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .lb_req (cfg_q[LB_REQ_W-1:0]),
        .mode   (mode),
        .status (lb_status)
    );

    lbk_route i_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .e1_mode     (e1_mode),
        .ln_rx_p     (ln_rx_p),
        .ln_rx_n     (ln_rx_n),
        .fmt_tx_p    (fmt_tx_p),
        .fmt_tx_n    (fmt_tx_n),
        .sys_tx_d    (sys_tx_d),
        .rx_pay_d    (rx_pay_d),
        .ovh_regen_d (ovh_regen_d),
        .ovh_pos     (ovh_pos),
        .ln_tx_p     (ln_tx_p),
        .ln_tx_n     (ln_tx_n),
        .fr_rx_p     (fr_rx_p),
        .fr_rx_n     (fr_rx_n),
        .tx_src_d    (tx_src_d),
        .rx_on_tclk  (rx_on_tclk),
        .tx_on_rclk  (tx_on_rclk)
    );

    AST_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_on_tclk && tx_on_rclk)); // R3
    AST_REMOTE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        lb_status[BIT_REM] |-> (ln_tx_p == fr_rx_p) && (ln_tx_n == fr_rx_n)); // R8
endmodule

// File: tb/test_lbk_path_ctrl.sv
// Bench for lbk_path_ctrl: a vector table walked by one loop, then directed
// checks for reset, write misses and the T1 all-ones pattern.
module test_lbk_path_ctrl;
    typedef struct packed {
        logic [4:0] cfg;
        logic       e1;
        logic [7:0] stim;  // {lrp, lrn, fp, fn, sys, pay, regen, ovh}
        logic [1:0] ltx;
        logic       ones;  // 1: line pattern checked separately
        logic [1:0] frx;
        logic       txs;
        logic [2:0] st;
        logic [1:0] ck;    // {rx_on_tclk, tx_on_rclk}
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{5'b00000, 1'b0, 8'b10_01_1000, 2'b01, 1'b0, 2'b10, 1'b1, 3'b000, 2'b00}, // R4
        '{5'b00000, 1'b1, 8'b01_10_0110, 2'b10, 1'b0, 2'b01, 1'b0, 3'b000, 2'b00}, // R4
        '{5'b00001, 1'b0, 8'b10_01_0100, 2'b00, 1'b1, 2'b01, 1'b0, 3'b001, 2'b10}, // R5
        '{5'b00001, 1'b1, 8'b10_01_1000, 2'b01, 1'b0, 2'b01, 1'b1, 3'b001, 2'b10}, // R6
        '{5'b00010, 1'b0, 8'b10_01_1010, 2'b01, 1'b0, 2'b10, 1'b0, 3'b010, 2'b01}, // R7
        '{5'b00010, 1'b1, 8'b01_10_1101, 2'b10, 1'b0, 2'b01, 1'b0, 3'b010, 2'b01}, // R7
        '{5'b00010, 1'b1, 8'b01_10_0100, 2'b10, 1'b0, 2'b01, 1'b1, 3'b010, 2'b01}, // R7
        '{5'b00100, 1'b0, 8'b10_01_0000, 2'b10, 1'b0, 2'b10, 1'b0, 3'b100, 2'b00}, // R8
        '{5'b00100, 1'b1, 8'b01_10_1000, 2'b01, 1'b0, 2'b01, 1'b1, 3'b100, 2'b00}, // R8
        '{5'b00111, 1'b0, 8'b10_01_1000, 2'b10, 1'b0, 2'b10, 1'b1, 3'b100, 2'b00}, // R3
        '{5'b00011, 1'b0, 8'b10_01_0101, 2'b01, 1'b0, 2'b10, 1'b0, 3'b010, 2'b01}, // R3
        '{5'b11000, 1'b0, 8'b10_01_1000, 2'b01, 1'b0, 2'b10, 1'b1, 3'b000, 2'b00}, // R9
        '{5'b10001, 1'b1, 8'b01_10_0000, 2'b10, 1'b0, 2'b10, 1'b0, 3'b001, 2'b10}  // R9
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [4:0] cfg_wdata = '0;
    logic e1_mode = 1'b0;
    logic ln_rx_p = 1'b0, ln_rx_n = 1'b0, fmt_tx_p = 1'b0, fmt_tx_n = 1'b0;
    logic sys_tx_d = 1'b0, rx_pay_d = 1'b0, ovh_regen_d = 1'b0, ovh_pos = 1'b0;
    logic ln_tx_p, ln_tx_n, fr_rx_p, fr_rx_n, tx_src_d, rx_on_tclk, tx_on_rclk;
    logic [2:0] lb_status;
    logic [4:0] cfg_q;
    int n_chk = 0;
    int n_err = 0;
    logic prev_p;

    always #10 clk = ~clk;

    lbk_path_ctrl i_lbk_path_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .e1_mode(e1_mode), .ln_rx_p(ln_rx_p), .ln_rx_n(ln_rx_n),
        .fmt_tx_p(fmt_tx_p), .fmt_tx_n(fmt_tx_n), .sys_tx_d(sys_tx_d),
        .rx_pay_d(rx_pay_d), .ovh_regen_d(ovh_regen_d), .ovh_pos(ovh_pos),
        .ln_tx_p(ln_tx_p), .ln_tx_n(ln_tx_n), .fr_rx_p(fr_rx_p), .fr_rx_n(fr_rx_n),
        .tx_src_d(tx_src_d), .rx_on_tclk(rx_on_tclk), .tx_on_rclk(tx_on_rclk),
        .lb_status(lb_status), .cfg_q(cfg_q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic [7:0] a, input logic [4:0] d);
        @(negedge clk);
        cfg_wr_en = en; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R1 cfg", {3'b0, cfg_q}, 8'h00);
        check("R1 status", {5'b0, lb_status}, 8'h00);
        check("R1 flags", {6'b0, rx_on_tclk, tx_on_rclk}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            write_cfg(1'b1, 8'h4A, TBL[k].cfg);
            e1_mode = TBL[k].e1;
            {ln_rx_p, ln_rx_n, fmt_tx_p, fmt_tx_n, sys_tx_d, rx_pay_d, ovh_regen_d, ovh_pos} = TBL[k].stim;
            #5;
            check("R2 load", {3'b0, cfg_q}, {3'b0, TBL[k].cfg});
            if (!TBL[k].ones)
                check("R4/R6/R8 ln_tx", {6'b0, ln_tx_p, ln_tx_n}, {6'b0, TBL[k].ltx});
            check("R5/R7 fr_rx", {6'b0, fr_rx_p, fr_rx_n}, {6'b0, TBL[k].frx});
            check("R7 tx_src", {7'b0, tx_src_d}, {7'b0, TBL[k].txs});
            check("R3 status", {5'b0, lb_status}, {5'b0, TBL[k].st});
            check("R5/R7 flags", {6'b0, rx_on_tclk, tx_on_rclk}, {6'b0, TBL[k].ck});
        end

        // R2: misses leave the register as last loaded (5'b10001)
        write_cfg(1'b1, 8'h4B, 5'b00100);
        #5 check("R2 addr 4B miss", {3'b0, cfg_q}, 8'h11);
        write_cfg(1'b1, 8'h49, 5'b00010);
        #5 check("R2 addr 49 miss", {3'b0, cfg_q}, 8'h11);
        write_cfg(1'b0, 8'h4A, 5'b00100);
        #5 check("R2 strobe low", {3'b0, cfg_q}, 8'h11);

        // R6: T1 framer loopback gives alternating marks
        write_cfg(1'b1, 8'h4A, 5'b00001);
        e1_mode = 1'b0; fmt_tx_p = 1'b0; fmt_tx_n = 1'b0;
        #5;
        prev_p = ln_tx_p;
        check("R6 rails differ", {7'b0, ln_tx_p ^ ln_tx_n}, 8'h01);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); #5;
            check("R6 rails differ", {7'b0, ln_tx_p ^ ln_tx_n}, 8'h01);
            check("R6 alternate", {7'b0, ln_tx_p}, {7'b0, ~prev_p});
            prev_p = ln_tx_p;
        end
        // R5: line receive ignored in framer loopback
        fmt_tx_p = 1'b1; fmt_tx_n = 1'b0; ln_rx_p = 1'b0; ln_rx_n = 1'b1;
        #1 check("R5 line ignored", {6'b0, fr_rx_p, fr_rx_n}, 8'h02);

        // R1: reset mid-operation clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #5;
        check("R1 cfg after reset", {3'b0, cfg_q}, 8'h00);
        check("R1 status after reset", {5'b0, lb_status}, 8'h00);
        check("R1 routing after reset", {6'b0, fr_rx_p, fr_rx_n}, 8'h01);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule